// File: doc/BRIEF.md
# Low-Power Wake-Up Controller

This block keeps track of the processor's power state (running, light sleep or deep sleep) and decides when a pending peripheral interrupt should bring the core back to running. It watches sixteen raw request lines. Each line has its own enable bit and its own 3-bit urgency field. A larger urgency value means more urgent.

Software asks for sleep with a one-cycle request. The request carries the target depth, a flag saying whether an interrupt handler is active, and that handler's urgency. The controller latches this context when it accepts the request. While asleep it evaluates every line against the latched context:
- In light sleep, any enabled line may wake the core.
- In deep sleep, only a fixed, parameterised set of lines may wake the core.
- If sleep was entered from inside a handler, a line must also be strictly more urgent than that handler.

A non-maskable supply-undervoltage event ranks above every line and always wakes. On a wake the controller returns to running, emits a one-cycle pulse and reports the winning line. Request line k corresponds to exception number 16+k. The vector fetch and the clock or power switching that follow a wake are outside this block.

Top module: `lpwake_ctrl`

## Requirements
- R1: After reset `pwr_mode` is 0 (running), `wake_pulse` and `wake_nmi` are 0, `wake_src` is 0, and the latched handler context is cleared.
- R2: In running mode with nothing eligible pending, a `sleep_req` moves `pwr_mode` on the next edge to the requested depth: 1 (light) when `sleep_deep`=0, and 2 (deep) when `sleep_deep`=1.
- R3: In light sleep, any line with both `irq_req` and `irq_en` set wakes the core. A requesting line whose enable bit is 0 has no effect.
- R4: In deep sleep, only lines whose bit is set in `DEEP_WAKE_MASK` can wake the core. The default mask holds lines 0 and 2. Requests on other lines leave the mode at 2.
- R5: When sleep was entered with `sleep_in_hdl`=1, a line wakes the core only if its urgency is strictly greater than the latched `sleep_hprio`. Equal or lower urgency has no effect.
- R6: Line i's urgency is `irq_prio[3i+2:3i]`. Among eligible lines, the most urgent wins. Ties go to the lowest line index.
- R7: `uv_flag_a` OR `uv_flag_b` wakes the core from either sleep depth regardless of enables, mask and handler gate. It outranks every line, and it reports `wake_nmi`=1 with `wake_src`=0.
- R8: A wake event sampled at a clock edge makes `wake_pulse` 1 for exactly one cycle after that edge. In that same cycle `pwr_mode` is 0 and `wake_src`/`wake_nmi` hold the winner. `wake_src` and `wake_nmi` keep their values until the next wake.
- R9: A `sleep_req` is rejected and the mode stays 0 with no pulse if a source that would be eligible under the requested context is already pending, including an undervoltage flag.
- R10: A `sleep_req` while asleep is ignored. The mode and the latched handler context are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 16 | Raw request lines |
| irq_en | input | 16 | Per-line enable |
| irq_prio | input | 48 | Per-line urgency, 3 bits per line, line i at [3i+2:3i] |
| sleep_req | input | 1 | Sleep request strobe |
| sleep_deep | input | 1 | Target depth: 0 light, 1 deep |
| sleep_in_hdl | input | 1 | Sleep requested from inside a handler |
| sleep_hprio | input | 3 | Urgency of the active handler |
| uv_flag_a | input | 1 | First supply undervoltage flag |
| uv_flag_b | input | 1 | Second supply undervoltage flag |
| pwr_mode | output | 2 | 0 running, 1 light sleep, 2 deep sleep |
| wake_pulse | output | 1 | One-cycle wake indication |
| wake_src | output | 4 | Index of winning line |
| wake_nmi | output | 1 | Last wake came from undervoltage |

## Verification
Errors in the latched sleep context show up only during a later sleep, and only at the ports:
- A lost handler flag or urgency appears as a premature wake on an equal-urgency line, one cycle after that line rises.
- A wrong depth appears either as `pwr_mode` differing from the request on the cycle after acceptance, or as a wake from a line outside the deep mask.

Errors in the arbitration appear on `wake_src` in the pulse cycle when several lines rise together. Errors in the acceptance logic appear as a mode change on the cycle after a request that should have been rejected or ignored.

// File: rtl/lpwake_pkg.sv
package lpwake_pkg;
   typedef enum logic [1:0] {
      PM_ACTIVE = 2'd0,
      PM_LIGHT  = 2'd1,
      PM_DEEP   = 2'd2
   } pmode_e;
endpackage

// File: rtl/lpwake_elig.sv
// Per-line eligibility against the current wake context.
module lpwake_elig #(
   parameter int                  NUM_LINES      = 16,
   parameter int                  PRIO_W         = 3,
   parameter logic [NUM_LINES-1:0] DEEP_WAKE_MASK = 16'h0005
) (
   input  logic [NUM_LINES-1:0]        req,
   input  logic [NUM_LINES-1:0]        en,
   input  logic [NUM_LINES*PRIO_W-1:0] prio_flat,
   input  logic                        ctx_deep,
   input  logic                        ctx_gate,
   input  logic [PRIO_W-1:0]           ctx_hprio,
   output logic [NUM_LINES-1:0]        elig
);
   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      logic [PRIO_W-1:0] p;
      logic              mask_ok;
      logic              gate_ok;
      assign p       = prio_flat[g*PRIO_W +: PRIO_W];
      assign mask_ok = !ctx_deep || DEEP_WAKE_MASK[g];
      assign gate_ok = !ctx_gate || (p > ctx_hprio);
      assign elig[g] = req[g] && en[g] && mask_ok && gate_ok;
   end
endmodule

// File: rtl/lpwake_arb.sv
// Picks the most urgent eligible line; ties resolve to the lowest index.
module lpwake_arb #(
   parameter int NUM_LINES = 16,
   parameter int PRIO_W    = 3,
   localparam int IDX_W    = $clog2(NUM_LINES)
) (
   input  logic [NUM_LINES-1:0]        elig,
   input  logic [NUM_LINES*PRIO_W-1:0] prio_flat,
   output logic                        any,
   output logic [IDX_W-1:0]            win_idx,
   output logic [PRIO_W-1:0]           win_prio
);
   always_comb begin
      any      = 1'b0;
      win_idx  = '0;
      win_prio = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (elig[i] && (!any || prio_flat[i*PRIO_W +: PRIO_W] > win_prio)) begin
            any      = 1'b1;
            win_idx  = IDX_W'(i);
            win_prio = prio_flat[i*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/lpwake_fsm.sv
// Power-mode state, latched sleep context and registered wake outputs.
module lpwake_fsm
   import lpwake_pkg::*;
#(
   parameter int PRIO_W = 3,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_req,
   input  logic              sleep_deep,
   input  logic              sleep_in_hdl,
   input  logic [PRIO_W-1:0] sleep_hprio,
   input  logic              hit,
   input  logic              nmi,
   input  logic [IDX_W-1:0]  win_idx,
   output pmode_e            mode,
   output logic              ctx_deep,
   output logic              ctx_gate,
   output logic [PRIO_W-1:0] ctx_hprio,
   output logic              wake_pulse,
   output logic [IDX_W-1:0]  wake_src,
   output logic              wake_nmi
);
   pmode_e            mode_q;
   logic              hdl_q;
   logic [PRIO_W-1:0] hprio_q;
   logic              is_active;

   assign is_active = (mode_q == PM_ACTIVE);
   assign ctx_deep  = is_active ? sleep_deep   : (mode_q == PM_DEEP);
   assign ctx_gate  = is_active ? sleep_in_hdl : hdl_q;
   assign ctx_hprio = is_active ? sleep_hprio  : hprio_q;
   assign mode      = mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= PM_ACTIVE;
         hdl_q      <= 1'b0;
         hprio_q    <= '0;
         wake_pulse <= 1'b0;
         wake_src   <= '0;
         wake_nmi   <= 1'b0;
      end else begin
         wake_pulse <= 1'b0;
         if (is_active) begin
            if (sleep_req && !hit) begin
               mode_q  <= sleep_deep ? PM_DEEP : PM_LIGHT;
               hdl_q   <= sleep_in_hdl;
               hprio_q <= sleep_hprio;
            end
         end else if (hit) begin
            mode_q     <= PM_ACTIVE;
            hdl_q      <= 1'b0;
            hprio_q    <= '0;
            wake_pulse <= 1'b1;
            wake_nmi   <= nmi;
            wake_src   <= nmi ? '0 : win_idx;
         end
      end
   end

   assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);
   assert_pulse_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> mode_q == PM_ACTIVE);
   assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (is_active && sleep_req && hit) |=> (mode_q == PM_ACTIVE && !wake_pulse));
   assert_ctx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_active && !hit) |=> ($stable(mode_q) && $stable(hdl_q) && $stable(hprio_q)));
   assert_entry_from_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != $past(mode_q) && mode_q != PM_ACTIVE) |-> $past(mode_q) == PM_ACTIVE);
endmodule

// File: rtl/lpwake_ctrl.sv
module lpwake_ctrl
   import lpwake_pkg::*;
#(
   parameter int                   NUM_LINES      = 16,
   parameter int                   PRIO_W         = 3,
   parameter logic [NUM_LINES-1:0] DEEP_WAKE_MASK = 16'h0005
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_LINES-1:0]           irq_req,
   input  logic [NUM_LINES-1:0]           irq_en,
   input  logic [NUM_LINES*PRIO_W-1:0]    irq_prio,
   input  logic                           sleep_req,
   input  logic                           sleep_deep,
   input  logic                           sleep_in_hdl,
   input  logic [PRIO_W-1:0]              sleep_hprio,
   input  logic                           uv_flag_a,
   input  logic                           uv_flag_b,
   output logic [1:0]                     pwr_mode,
   output logic                           wake_pulse,
   output logic [$clog2(NUM_LINES)-1:0]   wake_src,
   output logic                           wake_nmi
);
   localparam int IDX_W = $clog2(NUM_LINES);

   if (NUM_LINES < 2 || NUM_LINES > 64) begin : g_bad_lines
      $error("lpwake_ctrl: NUM_LINES must lie in 2..64");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("lpwake_ctrl: PRIO_W must lie in 1..8");
   end

   pmode_e             mode;
   logic               ctx_deep, ctx_gate;
   logic [PRIO_W-1:0]  ctx_hprio;
   logic [NUM_LINES-1:0] elig;
   logic               any;
   logic [IDX_W-1:0]   win_idx;
   logic [PRIO_W-1:0]  win_prio;
   logic               nmi;
   logic               hit;

   assign nmi = uv_flag_a | uv_flag_b;
   assign hit = nmi | any;

   lpwake_elig #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .DEEP_WAKE_MASK(DEEP_WAKE_MASK)) u_elig (
      .req(irq_req), .en(irq_en), .prio_flat(irq_prio),
      .ctx_deep(ctx_deep), .ctx_gate(ctx_gate), .ctx_hprio(ctx_hprio), .elig(elig));

   lpwake_arb #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_arb (
      .elig(elig), .prio_flat(irq_prio), .any(any), .win_idx(win_idx), .win_prio(win_prio));

   lpwake_fsm #(.PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_deep(sleep_deep),
      .sleep_in_hdl(sleep_in_hdl), .sleep_hprio(sleep_hprio), .hit(hit), .nmi(nmi),
      .win_idx(win_idx), .mode(mode), .ctx_deep(ctx_deep), .ctx_gate(ctx_gate),
      .ctx_hprio(ctx_hprio), .wake_pulse(wake_pulse), .wake_src(wake_src), .wake_nmi(wake_nmi));

   assign pwr_mode = mode;

   assert_deep_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_pulse && !wake_nmi && $past(pwr_mode) == 2'd2)
         |-> ((DEEP_WAKE_MASK >> wake_src) & NUM_LINES'(1)) != '0);
   assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_pulse && !wake_nmi && $past(ctx_gate)) |-> $past(win_prio) > $past(ctx_hprio));
   assert_src_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_pulse && !wake_nmi)
         |-> (($past(irq_req & irq_en) >> wake_src) & NUM_LINES'(1)) != '0);
   assert_nmi_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_mode != 2'd0 && nmi) |=> (wake_pulse && wake_nmi && wake_src == '0));
endmodule

// File: tb/lpwake_ctrl_tb_top.sv
module lpwake_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_req = '0, irq_en = '0;
   logic [47:0] irq_prio = '0;
   logic        sleep_req = 0, sleep_deep = 0, sleep_in_hdl = 0;
   logic [2:0]  sleep_hprio = '0;
   logic        uv_flag_a = 0, uv_flag_b = 0;
   logic [1:0]  pwr_mode;
   logic        wake_pulse, wake_nmi;
   logic [3:0]  wake_src;
   int          n_chk = 0, n_bad = 0, cyc = 0;

   lpwake_ctrl dut_i (.*);

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_bad++;
         $display("FAIL watchdog: act=%0d exp=<20000 cycles", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_prio(int line, int val);
      irq_prio[line*3 +: 3] = 3'(val);
   endtask

   task automatic go_sleep(bit deep, bit hdl, int hp);
      sleep_req = 1; sleep_deep = deep; sleep_in_hdl = hdl; sleep_hprio = 3'(hp);
      tick();
      sleep_req = 0; sleep_deep = 0; sleep_in_hdl = 0; sleep_hprio = '0;
   endtask

   task automatic clean();
      irq_req = '0; irq_en = '0; irq_prio = '0; uv_flag_a = 0; uv_flag_b = 0;
      tick();
   endtask

   task automatic expect_wake(string tag, int src, bit nmi);
      tick();
      chk({tag, " pulse"}, wake_pulse, 1);
      chk({tag, " mode"}, pwr_mode, 0);
      chk({tag, " src"}, wake_src, src);
      chk({tag, " nmi"}, wake_nmi, nmi);
      tick();
      chk({tag, " pulse drop R8"}, wake_pulse, 0);
      chk({tag, " src hold R8"}, wake_src, src);
   endtask

   task automatic t_reset();
      chk("R1 mode", pwr_mode, 0);
      chk("R1 pulse", wake_pulse, 0);
      chk("R1 src", wake_src, 0);
      chk("R1 nmi", wake_nmi, 0);
   endtask

   task automatic t_light();
      irq_en = '1;
      go_sleep(0, 0, 0);
      chk("R2 light entry", pwr_mode, 1);
      irq_req[5] = 1;
      expect_wake("R3 light wake line5", 5, 0);
      clean();
   endtask

   task automatic t_disabled();
      irq_en = 16'hFF7F;
      go_sleep(0, 0, 0);
      irq_req[7] = 1;
      tick(3);
      chk("R3 disabled line ignored mode", pwr_mode, 1);
      chk("R3 disabled line ignored pulse", wake_pulse, 0);
      irq_en[7] = 1;
      expect_wake("R3 enabled line7", 7, 0);
      clean();
   endtask

   task automatic t_deep();
      irq_en = '1;
      go_sleep(1, 0, 0);
      chk("R2 deep entry", pwr_mode, 2);
      irq_req[3] = 1;
      tick(3);
      chk("R4 line3 outside mask", pwr_mode, 2);
      irq_req[2] = 1;
      expect_wake("R4 line2 in mask", 2, 0);
      clean();
   endtask

   task automatic t_gate();
      irq_en = '1;
      set_prio(6, 4);
      go_sleep(0, 1, 4);
      irq_req[6] = 1;
      tick(3);
      chk("R5 equal urgency ignored", pwr_mode, 1);
      set_prio(9, 5);
      irq_req[9] = 1;
      expect_wake("R5 higher urgency line9", 9, 0);
      clean();
   endtask

   task automatic t_arb();
      irq_en = '1;
      set_prio(3, 2); set_prio(8, 6); set_prio(12, 6); set_prio(1, 5);
      go_sleep(0, 0, 0);
      irq_req = 16'h110A;
      expect_wake("R6 urgent tie lowest", 8, 0);
      clean();
      irq_en = '1;
      go_sleep(0, 0, 0);
      irq_req = 16'h0410;
      expect_wake("R6 all zero urgency", 4, 0);
      clean();
   endtask

   task automatic t_nmi();
      go_sleep(1, 1, 7);
      chk("R2 deep in handler entry", pwr_mode, 2);
      uv_flag_a = 1;
      expect_wake("R7 flag a deep", 0, 1);
      clean();
      irq_en = '1;
      set_prio(9, 7);
      go_sleep(0, 0, 0);
      irq_req[9] = 1; uv_flag_b = 1;
      expect_wake("R7 flag b outranks", 0, 1);
      clean();
   endtask

   task automatic t_reject();
      irq_en = '1;
      irq_req[4] = 1;
      go_sleep(0, 0, 0);
      chk("R9 pending line rejects", pwr_mode, 0);
      chk("R9 no pulse", wake_pulse, 0);
      clean();
      uv_flag_b = 1;
      go_sleep(1, 0, 0);
      chk("R9 undervoltage rejects", pwr_mode, 0);
      clean();
      irq_en = '1;
      set_prio(4, 2);
      irq_req[4] = 1;
      go_sleep(0, 1, 3);
      chk("R9 ineligible pending accepted", pwr_mode, 1);
      set_prio(4, 4);
      expect_wake("R5 urgency raised line4", 4, 0);
      clean();
   endtask

   task automatic t_ignored();
      irq_en = '1;
      go_sleep(0, 1, 5);
      go_sleep(1, 0, 0);
      chk("R10 request while asleep ignored", pwr_mode, 1);
      set_prio(11, 3);
      irq_req[11] = 1;
      tick(3);
      chk("R10 handler gate kept", pwr_mode, 1);
      set_prio(11, 6);
      expect_wake("R10 wake line11", 11, 0);
      clean();
   endtask

   initial begin
      tick(3);
      t_reset();
      rst_n = 1;
      tick(2);
      t_reset();
      t_light();
      t_disabled();
      t_deep();
      t_gate();
      t_arb();
      t_nmi();
      t_reject();
      t_ignored();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule